// File: doc/BRIEF.md
# Stream-to-Memory Receive Channel

This block drains packets from a streaming source into a memory buffer. Software sets a destination byte address and a receive-buffer length through an AXI4-Lite register port. Writing the length arms the channel, provided its run bit is already set. Stream words are gathered into a small burst buffer. The buffer is then written out through an AXI4 write master as incrementing bursts to consecutive addresses.

Reception finishes on a TLAST beat or when the buffer is full, whichever comes first. A packet that finishes early completes normally, and the channel reports the bytes it actually received. A packet that runs past the buffer raises an error and stops the channel. In header mode, the first stream word is a byte count from the producer. That word is consumed and not stored, and the channel then takes exactly that many bytes. Completion and error each have their own sticky flag and their own interrupt enable. A flag is raised only after the final write response has come back.

Top module: `s2mm_channel`

## Requirements
- R1: After reset, s_tready and irq are 0, and reads of CTRL (0x00), STATUS (0x04) and XFERD (0x10) return 0.
- R2: A LEN write arms the channel only while CTRL bit0 (run) is 1 and the channel is idle. While armed, STATUS bit0 (busy) reads 1. s_tready stays 0 whenever the channel is not armed.
- R3: Register map: CTRL bit0 run, bit1 done-interrupt enable, bit2 error-interrupt enable, bit3 header mode. STATUS bit0 busy, bit1 done, bit2 error. DEST (0x08) holds the destination byte address. LEN (0x0C) holds the buffer length. XFERD (0x10) holds the bytes received. CTRL, DEST and LEN read back as written.
- R4: Stream words are written in arrival order to DEST, DEST+4 and so on. Writes use INCR bursts (awburst 1) of at most BURST_MAX beats, with awsize 2 and all strobes set. wlast marks the beat numbered awlen.
- R5: A packet whose TLAST beat arrives at or before the buffer's last word sets done without error. XFERD then equals 4 times the number of words received.
- R6: If the buffer fills without a TLAST beat, the received words are still written. After that, s_tready stays 0, error is set and the run bit is cleared.
- R7: Done and error are raised only after the write response of the final burst has arrived. Until then, busy stays 1.
- R8: irq is (done and CTRL bit1) or (error and CTRL bit2). Writing 1 to STATUS bit1 or bit2 clears that flag.
- R9: In header mode, the low LEN_W bits of the first word give the byte count, rounded down to whole words. That word is not written to memory or counted. After the count is reached, done is set without error and s_tready is 0, even with no TLAST.
- R10: In header mode, a header count larger than the buffer sets error and clears run. No memory write is issued.
- R11: Only the low LEN_W bits of a LEN write are kept, and the value is rounded down to whole words. A length below one word does not arm the channel.
- R12: A write response other than OKAY (bresp not 0) sets error and clears run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_awaddr | input | 5 | Register write address |
| cfg_awvalid | input | 1 | Register write address valid |
| cfg_awready | output | 1 | Register write address ready |
| cfg_wdata | input | 32 | Register write data |
| cfg_wvalid | input | 1 | Register write data valid |
| cfg_wready | output | 1 | Register write data ready |
| cfg_bresp | output | 2 | Register write response (always OKAY) |
| cfg_bvalid | output | 1 | Register write response valid |
| cfg_bready | input | 1 | Register write response ready |
| cfg_araddr | input | 5 | Register read address |
| cfg_arvalid | input | 1 | Register read address valid |
| cfg_arready | output | 1 | Register read address ready |
| cfg_rdata | output | 32 | Register read data |
| cfg_rresp | output | 2 | Register read response (always OKAY) |
| cfg_rvalid | output | 1 | Register read data valid |
| cfg_rready | input | 1 | Register read data ready |
| s_tdata | input | DATA_W | Stream data |
| s_tvalid | input | 1 | Stream valid |
| s_tready | output | 1 | Stream ready |
| s_tlast | input | 1 | Stream end of packet |
| m_awaddr | output | ADDR_W | Burst start byte address |
| m_awlen | output | 8 | Burst beats minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type (INCR) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes |
| m_wlast | output | 1 | Last beat of burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume a memory slave that returns exactly one write response per burst, and only after that burst's wlast beat. They also assume the slave does not respond while no burst is outstanding. The stream is assumed to carry only full words. The stimulus meets these assumptions with a memory model that raises bvalid after a configurable number of cycles following wlast. Stream words are sent one at a time, each held until accepted or until a timeout shows the channel is refusing it. Register writes present address and data together.

// File: rtl/s2mm_channel.sv
module s2mm_channel #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BURST_MAX = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4:0]            cfg_awaddr,
  input  logic                  cfg_awvalid,
  output logic                  cfg_awready,
  input  logic [31:0]           cfg_wdata,
  input  logic                  cfg_wvalid,
  output logic                  cfg_wready,
  output logic [1:0]            cfg_bresp,
  output logic                  cfg_bvalid,
  input  logic                  cfg_bready,
  input  logic [4:0]            cfg_araddr,
  input  logic                  cfg_arvalid,
  output logic                  cfg_arready,
  output logic [31:0]           cfg_rdata,
  output logic [1:0]            cfg_rresp,
  output logic                  cfg_rvalid,
  input  logic                  cfg_rready,
  input  logic [DATA_W-1:0]     s_tdata,
  input  logic                  s_tvalid,
  output logic                  s_tready,
  input  logic                  s_tlast,
  output logic [ADDR_W-1:0]     m_awaddr,
  output logic [7:0]            m_awlen,
  output logic [2:0]            m_awsize,
  output logic [1:0]            m_awburst,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [DATA_W/8-1:0]   m_wstrb,
  output logic                  m_wlast,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  input  logic [1:0]            m_bresp,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  output logic                  irq
);
  localparam int BYTES = DATA_W / 8;
  localparam int SH    = $clog2(BYTES);
  localparam int FW    = $clog2(BURST_MAX + 1);
  localparam int IW    = $clog2(BURST_MAX);
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_DEST = 5'h08,
                         A_LEN = 5'h0C, A_XFER = 5'h10;

  typedef enum logic [2:0] {IDLE, HDR, FILL, AWR, WR, BW} st_t;

  st_t               st_q;
  logic              run_q, den_q, een_q, hdr_q, done_q, err_q;
  logic              bv_q, rv_q, ended_q, over_q, hph_q;
  logic [31:0]       rdata_q;
  logic [ADDR_W-1:0] dest_q, addr_q;
  logic [LEN_W-1:0]  len_q, xfer_q, rem_q;
  logic [FW-1:0]     fill_q, rd_q;
  logic [DATA_W-1:0] buf_q [BURST_MAX];

  logic             wr_go, rd_go, arm, busy;
  logic [LEN_W-1:0] wlen, hwords;

  assign wr_go  = cfg_awvalid && cfg_wvalid && !bv_q;
  assign rd_go  = cfg_arvalid && !rv_q;
  assign wlen   = cfg_wdata[LEN_W-1:0];
  assign hwords = s_tdata[LEN_W-1:0] >> SH;
  assign busy   = (st_q != IDLE);
  assign arm    = wr_go && cfg_awaddr == A_LEN && run_q && !busy && (wlen >> SH) != '0;

  assign cfg_awready = wr_go;
  assign cfg_wready  = wr_go;
  assign cfg_bvalid  = bv_q;
  assign cfg_bresp   = 2'b00;
  assign cfg_arready = rd_go;
  assign cfg_rvalid  = rv_q;
  assign cfg_rdata   = rdata_q;
  assign cfg_rresp   = 2'b00;

  assign s_tready  = (st_q == HDR) || (st_q == FILL);
  assign m_awvalid = (st_q == AWR);
  assign m_awaddr  = addr_q;
  assign m_awlen   = 8'(fill_q - FW'(1));
  assign m_awsize  = 3'(SH);
  assign m_awburst = 2'b01;
  assign m_wvalid  = (st_q == WR);
  assign m_wdata   = buf_q[rd_q[IW-1:0]];
  assign m_wstrb   = '1;
  assign m_wlast   = (rd_q == fill_q - FW'(1));
  assign m_bready  = (st_q == BW);
  assign irq       = (done_q && den_q) || (err_q && een_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bv_q <= 1'b0;
      rv_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_go) bv_q <= 1'b1;
      else if (cfg_bready) bv_q <= 1'b0;
      if (rd_go) begin
        rv_q <= 1'b1;
        case (cfg_araddr)
          A_CTRL:  rdata_q <= {28'd0, hdr_q, een_q, den_q, run_q};
          A_STAT:  rdata_q <= {29'd0, err_q, done_q, busy};
          A_DEST:  rdata_q <= 32'(dest_q);
          A_LEN:   rdata_q <= 32'(len_q);
          A_XFER:  rdata_q <= 32'(xfer_q);
          default: rdata_q <= '0;
        endcase
      end else if (cfg_rready) rv_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= IDLE;
      {run_q, den_q, een_q, hdr_q, done_q, err_q} <= '0;
      {ended_q, over_q, hph_q} <= '0;
      dest_q <= '0; addr_q <= '0;
      len_q <= '0; xfer_q <= '0; rem_q <= '0;
      fill_q <= '0; rd_q <= '0;
    end else begin
      if (wr_go) begin
        case (cfg_awaddr)
          A_CTRL: {hdr_q, een_q, den_q, run_q} <= cfg_wdata[3:0];
          A_STAT: begin
            if (cfg_wdata[1]) done_q <= 1'b0;
            if (cfg_wdata[2]) err_q <= 1'b0;
          end
          A_DEST: dest_q <= cfg_wdata[ADDR_W-1:0];
          A_LEN:  len_q <= wlen;
          default: ;
        endcase
      end
      case (st_q)
        IDLE: if (arm) begin
          st_q <= hdr_q ? HDR : FILL;
          rem_q <= wlen >> SH;
          addr_q <= dest_q;
          xfer_q <= '0;
          {ended_q, over_q, hph_q} <= '0;
        end
        HDR: if (s_tvalid) begin
          if (hwords > rem_q) begin
            err_q <= 1'b1; run_q <= 1'b0; st_q <= IDLE;
          end else if (hwords == '0) begin
            done_q <= 1'b1; st_q <= IDLE;
          end else begin
            rem_q <= hwords; hph_q <= 1'b1; st_q <= FILL;
          end
        end
        FILL: if (s_tvalid) begin
          buf_q[fill_q[IW-1:0]] <= s_tdata;
          fill_q <= fill_q + FW'(1);
          rem_q <= rem_q - LEN_W'(1);
          xfer_q <= xfer_q + LEN_W'(BYTES);
          if (s_tlast) begin
            ended_q <= 1'b1; st_q <= AWR;
          end else if (rem_q == LEN_W'(1)) begin
            ended_q <= 1'b1; over_q <= !hph_q; st_q <= AWR;
          end else if (fill_q == FW'(BURST_MAX - 1)) st_q <= AWR;
        end
        AWR: if (m_awready) begin
          rd_q <= '0; st_q <= WR;
        end
        WR: if (m_wready) begin
          rd_q <= rd_q + FW'(1);
          if (m_wlast) st_q <= BW;
        end
        BW: if (m_bvalid) begin
          addr_q <= addr_q + (ADDR_W'(fill_q) << SH);
          fill_q <= '0;
          if (m_bresp != 2'b00) begin
            err_q <= 1'b1; run_q <= 1'b0; st_q <= IDLE;
          end else if (ended_q) begin
            if (over_q) begin
              err_q <= 1'b1; run_q <= 1'b0;
            end else done_q <= 1'b1;
            st_q <= IDLE;
          end else st_q <= FILL;
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  // R7
  done_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) && $past(st_q != HDR) |-> $past(m_bvalid && m_bready));
  // R4
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));
  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> 32'(m_awlen) < BURST_MAX);
  // R4
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast));
  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> xfer_q <= len_q);
  // R6
  halt_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !run_q);
endmodule

// File: tb/test_s2mm_channel.sv
module test_s2mm_channel;
  localparam int DW = 32, AW = 32, LW = 16, BM = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  cfg_awaddr = '0, cfg_araddr = '0;
  logic        cfg_awvalid = 0, cfg_wvalid = 0, cfg_arvalid = 0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_awready, cfg_wready, cfg_bvalid, cfg_arready, cfg_rvalid;
  logic [1:0]  cfg_bresp, cfg_rresp;
  logic [31:0] cfg_rdata;
  logic [DW-1:0] s_tdata = '0;
  logic        s_tvalid = 0, s_tlast = 0, s_tready;
  logic [AW-1:0] m_awaddr;
  logic [7:0]  m_awlen;
  logic [2:0]  m_awsize;
  logic [1:0]  m_awburst;
  logic        m_awvalid, m_wlast, m_wvalid, m_bready, irq;
  logic [DW-1:0] m_wdata;
  logic [DW/8-1:0] m_wstrb;
  logic        m_bvalid;
  logic [1:0]  m_bresp;

  s2mm_channel #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW), .BURST_MAX(BM)) i_s2mm_channel (
    .clk, .rst_n,
    .cfg_awaddr, .cfg_awvalid, .cfg_awready, .cfg_wdata, .cfg_wvalid, .cfg_wready,
    .cfg_bresp, .cfg_bvalid, .cfg_bready(1'b1), .cfg_araddr, .cfg_arvalid, .cfg_arready,
    .cfg_rdata, .cfg_rresp, .cfg_rvalid, .cfg_rready(1'b1),
    .s_tdata, .s_tvalid, .s_tready, .s_tlast,
    .m_awaddr, .m_awlen, .m_awsize, .m_awburst, .m_awvalid, .m_awready(1'b1),
    .m_wdata, .m_wstrb, .m_wlast, .m_wvalid, .m_wready(1'b1),
    .m_bresp, .m_bvalid, .m_bready, .irq);

  int checks = 0, errors = 0;
  logic [31:0] exp_a [$];
  logic [31:0] exp_d [$];
  logic [1:0]  inj_bresp = 2'b00;
  int          bdelay = 0;

  logic [31:0] base, ea, ed;
  logic [7:0]  blen;
  int          beat_i = 0, bcnt = 0;
  logic        pend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bvalid <= 1'b0; m_bresp <= 2'b00; pend <= 1'b0;
    end else begin
      if (m_bvalid && m_bready) m_bvalid <= 1'b0;
      if (m_awvalid) begin
        base = m_awaddr; blen = m_awlen; beat_i = 0;
        checks++;
        if (m_awsize != 3'd2 || m_awburst != 2'd1 || int'(m_awlen) >= BM) begin
          errors++;
          $display("FAIL R4 burst size/type/len %0d/%0d/%0d expected 2/1/<%0d",
                   m_awsize, m_awburst, m_awlen, BM);
        end
      end
      if (m_wvalid) begin
        checks++;
        if (exp_a.size() == 0) begin
          errors++;
          $display("FAIL R4 write addr %h data %h expected no write", base + 32'(beat_i*4), m_wdata);
        end else begin
          ea = exp_a.pop_front(); ed = exp_d.pop_front();
          if (base + 32'(beat_i*4) != ea || m_wdata != ed || m_wstrb != 4'hF) begin
            errors++;
            $display("FAIL R4 write addr %h data %h strb %h expected %h %h f",
                     base + 32'(beat_i*4), m_wdata, m_wstrb, ea, ed);
          end
        end
        if (m_wlast != (beat_i == int'(blen))) begin
          errors++;
          $display("FAIL R4 wlast %0d at beat %0d expected beat %0d", m_wlast, beat_i, blen);
        end
        beat_i++;
        if (m_wlast) begin pend <= 1'b1; bcnt <= bdelay; end
      end else if (pend) begin
        if (bcnt == 0) begin m_bvalid <= 1'b1; m_bresp <= inj_bresp; pend <= 1'b0; end
        else bcnt <= bcnt - 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lite_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_awaddr = a; cfg_wdata = d; cfg_awvalid = 1; cfg_wvalid = 1;
    #1;
    while (!cfg_awready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cfg_awvalid = 0; cfg_wvalid = 0;
    #1;
  endtask

  task automatic lite_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_araddr = a; cfg_arvalid = 1;
    #1;
    while (!cfg_arready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cfg_arvalid = 0;
    #1;
    while (!cfg_rvalid) begin @(negedge clk); #1; end
    d = cfg_rdata;
  endtask

  task automatic put(input logic [31:0] d, input logic last, output logic acc);
    int n = 0;
    acc = 0;
    @(negedge clk);
    s_tdata = d; s_tlast = last; s_tvalid = 1;
    #1;
    while (!s_tready && n < 40) begin @(negedge clk); #1; n++; end
    if (s_tready) begin
      @(posedge clk);
      acc = 1;
      @(negedge clk);
    end
    s_tvalid = 0; s_tlast = 0;
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d);
    exp_a.push_back(a); exp_d.push_back(d);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      lite_rd(5'h04, s);
      if (!s[0]) break;
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] d;
    logic acc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;

    check("R1 tready", 32'(s_tready), 0);
    check("R1 irq", 32'(irq), 0);
    lite_rd(5'h04, d); check("R1 status", d, 0);
    lite_rd(5'h10, d); check("R1 xferd", d, 0);
    lite_rd(5'h00, d); check("R1 ctrl", d, 0);

    lite_wr(5'h0C, 32);
    lite_rd(5'h04, d); check("R2 not armed without run", d, 0);
    put(32'hDEAD0000, 1, acc); check("R2 no accept unarmed", 32'(acc), 0);

    lite_wr(5'h00, 32'h7);
    lite_wr(5'h08, 32'h1000);
    lite_rd(5'h00, d); check("R3 ctrl readback", d, 32'h7);
    lite_rd(5'h08, d); check("R3 dest readback", d, 32'h1000);

    bdelay = 20;
    lite_wr(5'h0C, 40);
    lite_rd(5'h04, d); check("R2 armed busy", d, 1);
    lite_rd(5'h0C, d); check("R3 len readback", d, 40);
    for (int i = 0; i < 6; i++) begin
      push(32'h1000 + 32'(i*4), 32'hA000_0000 + 32'(i));
      put(32'hA000_0000 + 32'(i), i == 5, acc);
    end
    lite_rd(5'h04, d); check("R7 busy before response", d, 1);
    wait_idle();
    bdelay = 0;
    lite_rd(5'h04, d); check("R5 done after early tlast", d, 2);
    lite_rd(5'h10, d); check("R5 xferd", d, 24);
    check("R8 irq on done", 32'(irq), 1);
    check("R4 all words written", exp_a.size(), 0);
    lite_wr(5'h04, 32'h6);
    check("R8 irq cleared", 32'(irq), 0);
    lite_rd(5'h04, d); check("R8 status cleared", d, 0);

    lite_wr(5'h08, 32'h2000);
    lite_wr(5'h0C, 16);
    for (int i = 0; i < 4; i++) begin
      push(32'h2000 + 32'(i*4), 32'hB000_0000 + 32'(i));
      put(32'hB000_0000 + 32'(i), i == 3, acc);
    end
    wait_idle();
    lite_rd(5'h04, d); check("R5 exact fit done", d, 2);
    lite_rd(5'h10, d); check("R5 exact fit xferd", d, 16);
    lite_wr(5'h04, 32'h6);

    lite_wr(5'h08, 32'h3000);
    lite_wr(5'h0C, 12);
    for (int i = 0; i < 3; i++) begin
      push(32'h3000 + 32'(i*4), 32'hC000_0000 + 32'(i));
      put(32'hC000_0000 + 32'(i), 0, acc);
    end
    put(32'hC000_0003, 0, acc); check("R6 tready low after full", 32'(acc), 0);
    wait_idle();
    lite_rd(5'h04, d); check("R6 error set", d, 4);
    lite_rd(5'h00, d); check("R6 run cleared", d, 6);
    lite_rd(5'h10, d); check("R6 xferd", d, 12);
    check("R6 irq on error", 32'(irq), 1);
    check("R6 words written", exp_a.size(), 0);
    lite_wr(5'h04, 32'h6);

    lite_wr(5'h00, 32'h5);
    lite_wr(5'h08, 32'h4000);
    lite_wr(5'h0C, 8);
    for (int i = 0; i < 2; i++) begin
      push(32'h4000 + 32'(i*4), 32'hD000_0000 + 32'(i));
      put(32'hD000_0000 + 32'(i), i == 1, acc);
    end
    wait_idle();
    lite_rd(5'h04, d); check("R8 done flag", d, 2);
    check("R8 done irq masked", 32'(irq), 0);
    lite_wr(5'h00, 32'h3);
    check("R8 done irq enabled", 32'(irq), 1);
    lite_wr(5'h04, 32'h6);

    lite_wr(5'h00, 32'hB);
    lite_wr(5'h08, 32'h5000);
    lite_wr(5'h0C, 64);
    put(32'd20, 0, acc); check("R9 header accepted", 32'(acc), 1);
    for (int i = 0; i < 5; i++) begin
      push(32'h5000 + 32'(i*4), 32'hE000_0000 + 32'(i));
      put(32'hE000_0000 + 32'(i), 0, acc);
    end
    put(32'hE000_0005, 0, acc); check("R9 stop at header count", 32'(acc), 0);
    wait_idle();
    lite_rd(5'h04, d); check("R9 done without error", d, 2);
    lite_rd(5'h10, d); check("R9 xferd excludes header", d, 20);
    check("R9 words written", exp_a.size(), 0);
    lite_wr(5'h04, 32'h6);

    lite_wr(5'h0C, 8);
    put(32'd12, 0, acc);
    wait_idle();
    lite_rd(5'h04, d); check("R10 header over buffer error", d, 4);
    lite_rd(5'h00, d); check("R10 run cleared", d, 32'hA);
    check("R10 nothing written", exp_a.size(), 0);
    lite_wr(5'h04, 32'h6);
    lite_wr(5'h00, 32'h7);

    lite_wr(5'h08, 32'h6000);
    lite_wr(5'h0C, 32'h0001_0003);
    lite_rd(5'h04, d); check("R11 sub-word length not armed", d, 0);
    lite_wr(5'h0C, 32'h0001_0008);
    lite_rd(5'h0C, d); check("R11 length masked", d, 8);
    for (int i = 0; i < 2; i++) begin
      push(32'h6000 + 32'(i*4), 32'hF000_0000 + 32'(i));
      put(32'hF000_0000 + 32'(i), 0, acc);
    end
    put(32'hF000_0002, 0, acc); check("R11 masked limit stalls", 32'(acc), 0);
    wait_idle();
    lite_rd(5'h04, d); check("R11 masked limit error", d, 4);
    lite_wr(5'h04, 32'h6);
    lite_wr(5'h00, 32'h7);

    inj_bresp = 2'b10;
    lite_wr(5'h08, 32'h7000);
    lite_wr(5'h0C, 8);
    for (int i = 0; i < 2; i++) begin
      push(32'h7000 + 32'(i*4), 32'h1100_0000 + 32'(i));
      put(32'h1100_0000 + 32'(i), i == 1, acc);
    end
    wait_idle();
    inj_bresp = 2'b00;
    lite_rd(5'h04, d); check("R12 bad response error", d, 4);
    lite_rd(5'h00, d); check("R12 run cleared", d, 6);
    check("R12 words written", exp_a.size(), 0);

    report();
  end
endmodule